// File: doc/BRIEF.md
# Fetch Group Instruction Extractor

This block sits between a per-thread line buffer and the decode stage. When a fetch request arrives, it carries one buffered 32-byte cache line, the thread's current PC and next-PC, and a translation-fault indication. In that same cycle the block unrolls the line into a group of up to four fixed 4-byte instructions. It asks an external branch predictor about each slot through a per-slot PC output and takes back a taken bit and a target. The group, its per-slot PCs and sequence numbers, and the updated PC pair are registered and appear one cycle later as a valid-masked slot array with a count.

A group stops at the end of the line, at the width limit, after a control instruction predicted taken, or after a quiesce instruction. A small status machine tracks the thread. In `RUN` requests are served. A quiesce instruction moves the thread to `QUIESCE_WAIT`, and a translation fault moves it to `TRAP_WAIT`. Both waiting states ignore requests until `wake` returns the thread to `RUN`. The transitions are: RUN->QUIESCE_WAIT (quiesce emitted), RUN->TRAP_WAIT (faulting request), QUIESCE_WAIT->RUN and TRAP_WAIT->RUN (wake). The parameter `DELAY_SLOT` selects how a control instruction advances the PC pair.

Top module: `fetch_group_extractor`

## Requirements
- R1: The first slot reads the line word selected by PC bits [4:2], and that slot's PC is the request PC.
- R2: Slots are emitted in order while the word index stays below 8 and fewer than 4 slots have been emitted. `out_count` equals the number of set bits in `out_slot_valid`, and those bits form a prefix.
- R3: An instruction whose bits [31:28] equal 4'hB is a control instruction. A control instruction whose slot's predictor taken bit is 1 is the last slot of its group. The taken bit has no effect on any other instruction.
- R4: For a non-control instruction, the next PC is the old next-PC and the next next-PC is that value plus 4.
- R5: With `DELAY_SLOT`=0, a control instruction sets PC to the predictor target when taken and to PC+4 otherwise, and next-PC to the new PC+4.
- R6: With `DELAY_SLOT`=1, a control instruction sets PC to the old next-PC, and next-PC to the target when taken and to the old next-PC+4 otherwise.
- R7: An instruction whose bits [31:28] equal 4'hF is a quiesce instruction. It is emitted, ends the group, and moves the state (`thread_state`, RUN=0, QUIESCE_WAIT=1, TRAP_WAIT=2) to QUIESCE_WAIT.
- R8: A request with `req_fault`=1 in RUN yields exactly one slot holding 32'h0 with `out_fault`=1, leaves the PC pair unchanged, and moves the state to TRAP_WAIT.
- R9: Each emitted slot carries a sequence number from a global counter. The counter starts at 1 after reset and advances by one per emitted instruction.
- R10: A slot's redirect flag is set when its PC plus 4 differs from its next-PC.
- R11: In QUIESCE_WAIT or TRAP_WAIT, requests produce no output and do not advance the sequence counter. `wake` returns the state to RUN.
- R12: After reset, `out_valid` is 0, no slot is valid, and the state is RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Fetch request strobe |
| req_pc | input | 32 | Thread PC |
| req_npc | input | 32 | Thread next-PC |
| req_line | input | 256 | Buffered line, word k at bits [32k+31:32k] |
| req_fault | input | 1 | Address translation fault for this request |
| wake | input | 1 | Return a waiting thread to RUN |
| pred_pc | output | 128 | Per-slot PC presented to the predictor |
| pred_taken | input | 4 | Per-slot predicted-taken bit |
| pred_target | input | 128 | Per-slot predicted target |
| out_valid | output | 1 | Registered group present |
| out_count | output | 3 | Number of valid slots |
| out_slot_valid | output | 4 | Valid mask per slot |
| out_inst | output | 128 | Instruction per slot |
| out_pc | output | 128 | PC per slot |
| out_seq | output | 64 | Sequence number per slot |
| out_redir | output | 4 | Redirect flag per slot |
| out_fault | output | 1 | Group is a faulting no-op |
| out_pc_next | output | 32 | Updated PC |
| out_npc_next | output | 32 | Updated next-PC |
| thread_state | output | 2 | Thread status |

## Verification
The hardest case to reach is a state in which the PC pair and the line position disagree. This happens when the next-PC does not follow the PC, and the chain has to walk line words in order while the slot PCs jump to the next-PC. The stimulus reaches it with a table entry whose next-PC points far from the PC. The bench checks that slot PCs, redirect flags and the final pair follow the next-PC while the count still obeys the line and width limits. A second instance built with a delay slot shares every input, so the same control instruction is checked under both PC-advance rules in one step. The waiting states are reached by placing a quiesce word in the line, or by raising the fault input. Each waiting state is then probed with a request that must leave no trace on the outputs or on the sequence numbers.

// File: rtl/fgx_pkg.sv
package fgx_pkg;
    typedef enum logic [1:0] {
        ST_RUN          = 2'd0,
        ST_QUIESCE_WAIT = 2'd1,
        ST_TRAP_WAIT    = 2'd2
    } fgx_state_e;

    localparam logic [3:0] OP_CTRL    = 4'hB;
    localparam logic [3:0] OP_QUIESCE = 4'hF;
endpackage

// File: rtl/fgx_slot.sv
module fgx_slot #(
    parameter int XLEN       = 32,
    parameter int LINE_WORDS = 8,
    parameter int OFF_W      = 4,
    parameter int DELAY_SLOT = 0
) (
    input  logic                       alive_in,
    input  logic [XLEN-1:0]            pc_in,
    input  logic [XLEN-1:0]            npc_in,
    input  logic [OFF_W-1:0]           off_in,
    input  logic [LINE_WORDS*XLEN-1:0] line,
    input  logic                       taken_in,
    input  logic [XLEN-1:0]            target_in,
    output logic                       valid,
    output logic [XLEN-1:0]            inst,
    output logic [XLEN-1:0]            pc_out,
    output logic [XLEN-1:0]            npc_out,
    output logic [OFF_W-1:0]           off_out,
    output logic                       alive_out,
    output logic                       quiesce,
    output logic                       redir
);
    import fgx_pkg::*;

    localparam logic [XLEN-1:0] ISZ = XLEN'(XLEN / 8);

    logic [XLEN-1:0] word;
    logic            is_ctrl;
    logic            taken;
    logic [XLEN-1:0] ctl_pc;
    logic [XLEN-1:0] ctl_npc;

    assign word = line[off_in[OFF_W-2:0]*XLEN +: XLEN];

    generate
        if (DELAY_SLOT != 0) begin : g_ds
            always_comb begin
                ctl_pc  = npc_in;
                ctl_npc = taken ? target_in : npc_in + ISZ;
            end
        end else begin : g_nods
            always_comb begin
                ctl_pc  = taken ? target_in : pc_in + ISZ;
                ctl_npc = ctl_pc + ISZ;
            end
        end
    endgenerate

    always_comb begin
        valid     = alive_in && (off_in < OFF_W'(LINE_WORDS));
        inst      = valid ? word : '0;
        is_ctrl   = valid && (word[XLEN-1 -: 4] == OP_CTRL);
        quiesce   = valid && (word[XLEN-1 -: 4] == OP_QUIESCE);
        taken     = is_ctrl && taken_in;
        pc_out    = pc_in;
        npc_out   = npc_in;
        off_out   = off_in;
        if (valid) begin
            off_out = off_in + 1'b1;
            if (is_ctrl) begin
                pc_out  = ctl_pc;
                npc_out = ctl_npc;
            end else begin
                pc_out  = npc_in;
                npc_out = npc_in + ISZ;
            end
        end
        alive_out = valid && !taken && !quiesce;
        redir     = valid && ((pc_in + ISZ) != npc_in);
    end
endmodule

// File: rtl/fgx_status.sv
module fgx_status (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic                fault,
    input  logic                quiesce_hit,
    input  logic                wake,
    output fgx_pkg::fgx_state_e state
);
    import fgx_pkg::*;

    fgx_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (accept && fault)            state_d = ST_TRAP_WAIT;
                else if (accept && quiesce_hit) state_d = ST_QUIESCE_WAIT;
            end
            ST_QUIESCE_WAIT: if (wake) state_d = ST_RUN;
            ST_TRAP_WAIT:    if (wake) state_d = ST_RUN;
            default:         state_d = ST_RUN;
        endcase
    end

    assign state = state_q;

    // R7: quiescing is only entered from a served group holding a quiesce word
    p_quiesce_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QUIESCE_WAIT && $past(state_q) == ST_RUN) |->
            $past(accept && quiesce_hit && !fault));

    // R11: a waiting state is left only through wake
    p_wait_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != ST_RUN && state_q == ST_RUN) |-> $past(wake));
endmodule

// File: rtl/fetch_group_extractor.sv
module fetch_group_extractor #(
    parameter int XLEN       = 32,
    parameter int LINE_BYTES = 32,
    parameter int WIDTH      = 4,
    parameter int SEQ_W      = 16,
    parameter int DELAY_SLOT = 0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [XLEN-1:0]                   req_pc,
    input  logic [XLEN-1:0]                   req_npc,
    input  logic [LINE_BYTES*8-1:0]           req_line,
    input  logic                              req_fault,
    input  logic                              wake,
    output logic [WIDTH*XLEN-1:0]             pred_pc,
    input  logic [WIDTH-1:0]                  pred_taken,
    input  logic [WIDTH*XLEN-1:0]             pred_target,
    output logic                              out_valid,
    output logic [$clog2(WIDTH+1)-1:0]        out_count,
    output logic [WIDTH-1:0]                  out_slot_valid,
    output logic [WIDTH*XLEN-1:0]             out_inst,
    output logic [WIDTH*XLEN-1:0]             out_pc,
    output logic [WIDTH*SEQ_W-1:0]            out_seq,
    output logic [WIDTH-1:0]                  out_redir,
    output logic                              out_fault,
    output logic [XLEN-1:0]                   out_pc_next,
    output logic [XLEN-1:0]                   out_npc_next,
    output logic [1:0]                        thread_state
);
    import fgx_pkg::*;

    localparam int ISZ_B      = XLEN / 8;
    localparam int LINE_WORDS = LINE_BYTES / ISZ_B;
    localparam int WIDX_W     = $clog2(LINE_WORDS);
    localparam int OFF_W      = WIDX_W + 1;
    localparam int LSB        = $clog2(ISZ_B);
    localparam int CNT_W      = $clog2(WIDTH + 1);

    logic [XLEN-1:0]  c_pc    [WIDTH+1];
    logic [XLEN-1:0]  c_npc   [WIDTH+1];
    logic [OFF_W-1:0] c_off   [WIDTH+1];
    logic             c_alive [WIDTH+1];
    logic [WIDTH-1:0] s_valid, s_quiesce, s_redir;
    logic [XLEN-1:0]  s_inst  [WIDTH];
    logic [CNT_W-1:0] s_count;
    logic [SEQ_W-1:0] seq_q;
    logic             accept;
    fgx_state_e       state;

    assign c_pc[0]    = req_pc;
    assign c_npc[0]   = req_npc;
    assign c_off[0]   = {1'b0, req_pc[LSB +: WIDX_W]};
    assign c_alive[0] = 1'b1;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_slot
            fgx_slot #(
                .XLEN(XLEN), .LINE_WORDS(LINE_WORDS),
                .OFF_W(OFF_W), .DELAY_SLOT(DELAY_SLOT)
            ) u_slot (
                .alive_in (c_alive[i]),
                .pc_in    (c_pc[i]),
                .npc_in   (c_npc[i]),
                .off_in   (c_off[i]),
                .line     (req_line),
                .taken_in (pred_taken[i]),
                .target_in(pred_target[i*XLEN +: XLEN]),
                .valid    (s_valid[i]),
                .inst     (s_inst[i]),
                .pc_out   (c_pc[i+1]),
                .npc_out  (c_npc[i+1]),
                .off_out  (c_off[i+1]),
                .alive_out(c_alive[i+1]),
                .quiesce  (s_quiesce[i]),
                .redir    (s_redir[i])
            );
            assign pred_pc[i*XLEN +: XLEN] = c_pc[i];
        end
    endgenerate

    always_comb begin
        s_count = '0;
        for (int i = 0; i < WIDTH; i++) s_count = s_count + CNT_W'(s_valid[i]);
    end

    assign accept = req_valid && (state == ST_RUN);

    fgx_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .fault      (req_fault),
        .quiesce_hit(|s_quiesce),
        .wake       (wake),
        .state      (state)
    );

    assign thread_state = state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q          <= SEQ_W'(1);
            out_valid      <= 1'b0;
            out_count      <= '0;
            out_slot_valid <= '0;
            out_inst       <= '0;
            out_pc         <= '0;
            out_seq        <= '0;
            out_redir      <= '0;
            out_fault      <= 1'b0;
            out_pc_next    <= '0;
            out_npc_next   <= '0;
        end else if (accept) begin
            out_valid <= 1'b1;
            for (int i = 0; i < WIDTH; i++)
                out_seq[i*SEQ_W +: SEQ_W] <= seq_q + SEQ_W'(i);
            if (req_fault) begin
                seq_q          <= seq_q + SEQ_W'(1);
                out_count      <= CNT_W'(1);
                out_slot_valid <= WIDTH'(1);
                out_inst       <= '0;
                out_pc         <= {{((WIDTH-1)*XLEN){1'b0}}, req_pc};
                out_redir      <= '0;
                out_fault      <= 1'b1;
                out_pc_next    <= req_pc;
                out_npc_next   <= req_npc;
            end else begin
                seq_q          <= seq_q + SEQ_W'(s_count);
                out_count      <= s_count;
                out_slot_valid <= s_valid;
                for (int i = 0; i < WIDTH; i++) begin
                    out_inst[i*XLEN +: XLEN] <= s_inst[i];
                    out_pc[i*XLEN +: XLEN]   <= s_valid[i] ? c_pc[i] : '0;
                end
                out_redir      <= s_redir;
                out_fault      <= 1'b0;
                out_pc_next    <= c_pc[WIDTH];
                out_npc_next   <= c_npc[WIDTH];
            end
        end else begin
            out_valid      <= 1'b0;
            out_count      <= '0;
            out_slot_valid <= '0;
            out_fault      <= 1'b0;
        end
    end

    // R2: the valid mask is a prefix whose population equals the count
    p_count_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_slot_valid) == int'(out_count)
                       && ((out_slot_valid & (out_slot_valid + 1'b1)) == '0)));

    // R9: the counter has moved past the last sequence number handed out
    p_seq_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (seq_q == out_seq[0 +: SEQ_W] + SEQ_W'(out_count)));

    // R8: a faulting group is a single slot
    p_fault_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault) |-> (out_count == CNT_W'(1)));

    // R11: a request met by a waiting thread leaves no group
    p_wait_ignores_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && state != ST_RUN) |=> !out_valid);
endmodule

// File: tb/fetch_group_extractor_tb.sv
module fetch_group_extractor_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_pc = '0, req_npc = '0;
    logic [255:0] req_line = '0;
    logic         req_fault = 1'b0;
    logic         wake = 1'b0;
    logic [3:0]   pred_taken = '0;
    logic [127:0] pred_target;
    logic [127:0] pred_pc, pred_pc_ds;
    logic         out_valid, out_valid_ds;
    logic [2:0]   out_count, out_count_ds;
    logic [3:0]   out_slot_valid, out_slot_valid_ds;
    logic [127:0] out_inst, out_inst_ds, out_pc, out_pc_ds;
    logic [63:0]  out_seq, out_seq_ds;
    logic [3:0]   out_redir, out_redir_ds;
    logic         out_fault, out_fault_ds;
    logic [31:0]  out_pc_next, out_npc_next, out_pc_next_ds, out_npc_next_ds;
    logic [1:0]   thread_state, thread_state_ds;

    int checks = 0;
    int fails  = 0;
    int exp_seq = 1;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign pred_target = {32'h4300, 32'h4200, 32'h4100, 32'h4000};

    fetch_group_extractor u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
        .req_npc(req_npc), .req_line(req_line), .req_fault(req_fault),
        .wake(wake), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_target(pred_target), .out_valid(out_valid),
        .out_count(out_count), .out_slot_valid(out_slot_valid),
        .out_inst(out_inst), .out_pc(out_pc), .out_seq(out_seq),
        .out_redir(out_redir), .out_fault(out_fault),
        .out_pc_next(out_pc_next), .out_npc_next(out_npc_next),
        .thread_state(thread_state));

    fetch_group_extractor #(.DELAY_SLOT(1)) u_dut_ds (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
        .req_npc(req_npc), .req_line(req_line), .req_fault(req_fault),
        .wake(wake), .pred_pc(pred_pc_ds), .pred_taken(pred_taken),
        .pred_target(pred_target), .out_valid(out_valid_ds),
        .out_count(out_count_ds), .out_slot_valid(out_slot_valid_ds),
        .out_inst(out_inst_ds), .out_pc(out_pc_ds), .out_seq(out_seq_ds),
        .out_redir(out_redir_ds), .out_fault(out_fault_ds),
        .out_pc_next(out_pc_next_ds), .out_npc_next(out_npc_next_ds),
        .thread_state(thread_state_ds));

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] npc;
        logic [7:0]  cmask;
        logic [3:0]  tmask;
        logic [2:0]  cnt;
        logic [31:0] epc;
        logic [31:0] enpc;
        logic [3:0]  redir;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{32'h100, 32'h104, 8'h00, 4'b0000, 3'd4, 32'h110,  32'h114,  4'b0000},
        '{32'h118, 32'h11C, 8'h00, 4'b0000, 3'd2, 32'h120,  32'h124,  4'b0000},
        '{32'h200, 32'h204, 8'h02, 4'b0010, 3'd2, 32'h4100, 32'h4104, 4'b0000},
        '{32'h200, 32'h204, 8'h02, 4'b0000, 3'd4, 32'h210,  32'h214,  4'b0000},
        '{32'h204, 32'h208, 8'h02, 4'b0001, 3'd1, 32'h4000, 32'h4004, 4'b0000},
        '{32'h300, 32'h304, 8'h00, 4'b1111, 3'd4, 32'h310,  32'h314,  4'b0000},
        '{32'h100, 32'h500, 8'h00, 4'b0000, 3'd4, 32'h50C,  32'h510,  4'b0001},
        '{32'h11C, 32'h120, 8'h00, 4'b0000, 3'd1, 32'h120,  32'h124,  4'b0000}
    };

    function automatic logic [255:0] mk_line(input logic [7:0] cm, input logic [7:0] qm);
        logic [255:0] l;
        for (int k = 0; k < 8; k++) begin
            if (cm[k])      l[k*32 +: 32] = 32'hB000_0000 | 32'(k);
            else if (qm[k]) l[k*32 +: 32] = 32'hF000_0000 | 32'(k);
            else            l[k*32 +: 32] = 32'h1000_0000 | 32'(k);
        end
        return l;
    endfunction

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] pc, input logic [31:0] npc,
                        input logic [7:0] cm, input logic [7:0] qm,
                        input logic [3:0] tm, input logic flt);
        @(negedge clk);
        req_valid = 1'b1; req_pc = pc; req_npc = npc;
        req_line = mk_line(cm, qm); pred_taken = tm; req_fault = flt;
        @(negedge clk);
        req_valid = 1'b0; req_fault = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 out_valid", 64'(out_valid), 64'd0);
        chk("R12 slot mask", 64'(out_slot_valid), 64'd0);
        chk("R12 state", 64'(thread_state), 64'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            send(VECS[v].pc, VECS[v].npc, VECS[v].cmask, 8'h00, VECS[v].tmask, 1'b0);
            chk("R2 out_valid", 64'(out_valid), 64'd1);
            chk("R2 R3 count", 64'(out_count), 64'(VECS[v].cnt));
            chk("R4 R5 pc_next", 64'(out_pc_next), 64'(VECS[v].epc));
            chk("R4 R5 npc_next", 64'(out_npc_next), 64'(VECS[v].enpc));
            chk("R1 slot0 pc", 64'(out_pc[31:0]), 64'(VECS[v].pc));
            chk("R1 slot0 inst", 64'(out_inst[31:0]),
                64'(mk_line(VECS[v].cmask, 8'h00)[VECS[v].pc[4:2]*32 +: 32]));
            chk("R10 redir", 64'(out_redir), 64'(VECS[v].redir));
            chk("R9 slot0 seq", 64'(out_seq[15:0]), 64'(exp_seq));
            exp_seq += int'(VECS[v].cnt);
        end

        // R6 / R5: control at word0 taken, both advance rules
        send(32'h200, 32'h204, 8'h01, 8'h00, 4'b0001, 1'b0);
        chk("R5 pc taken", 64'(out_pc_next), 64'h4000);
        chk("R6 pc taken", 64'(out_pc_next_ds), 64'h204);
        chk("R6 npc taken", 64'(out_npc_next_ds), 64'h4000);
        chk("R6 count taken", 64'(out_count_ds), 64'd1);
        exp_seq += 1;
        send(32'h200, 32'h204, 8'h01, 8'h00, 4'b0000, 1'b0);
        chk("R6 pc not taken", 64'(out_pc_next_ds), 64'h210);
        chk("R6 npc not taken", 64'(out_npc_next_ds), 64'h214);
        exp_seq += 4;

        // R7: quiesce at word1 ends group and waits
        send(32'h100, 32'h104, 8'h00, 8'h02, 4'b0000, 1'b0);
        chk("R7 count", 64'(out_count), 64'd2);
        chk("R7 inst", 64'(out_inst[63:32]), 64'hF000_0001);
        chk("R7 state", 64'(thread_state), 64'd1);
        exp_seq += 2;
        send(32'h100, 32'h104, 8'h00, 8'h00, 4'b0000, 1'b0);
        chk("R11 ignored in quiesce", 64'(out_valid), 64'd0);
        pulse_wake();
        chk("R11 wake from quiesce", 64'(thread_state), 64'd0);

        // R8: faulting request
        send(32'h340, 32'h344, 8'h00, 8'h00, 4'b0000, 1'b1);
        chk("R8 count", 64'(out_count), 64'd1);
        chk("R8 fault flag", 64'(out_fault), 64'd1);
        chk("R8 nop", 64'(out_inst[31:0]), 64'd0);
        chk("R8 pc kept", 64'(out_pc_next), 64'h340);
        chk("R8 npc kept", 64'(out_npc_next), 64'h344);
        chk("R8 state", 64'(thread_state), 64'd2);
        chk("R9 fault seq", 64'(out_seq[15:0]), 64'(exp_seq));
        exp_seq += 1;
        send(32'h100, 32'h104, 8'h00, 8'h00, 4'b0000, 1'b0);
        chk("R11 ignored in trap", 64'(out_valid), 64'd0);
        pulse_wake();
        chk("R11 wake from trap", 64'(thread_state), 64'd0);

        // R9: counter untouched by ignored requests
        send(32'h100, 32'h104, 8'h00, 8'h00, 4'b0000, 1'b0);
        chk("R9 seq after waits", 64'(out_seq[15:0]), 64'(exp_seq));
        chk("R9 slot3 seq", 64'(out_seq[63:48]), 64'(exp_seq + 3));

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule